// File: doc/BRIEF.md
# Sliding-Window Viterbi Traceback Unit

This block holds the survivor decisions of a convolutional-code trellis in a local array and recovers the decoded bits by walking that trellis backwards. A state-metric unit writes one decision vector per trellis stage. Each vector has one bit per state, and that bit tells which of the two predecessors survived. When a frame is complete, a start pulse with a mode code and window lengths launches the traceback. The decoded bits leave the block as 32-bit words on a valid/ready stream.

The block offers three modes. The tailed mode makes a single backward pass over a frame that ends with K-1 tail stages. The convergent mode splits the frame into windows of R decoded stages. Each window except the last is traced over C extra stages first, so that the path can converge before any bit is kept. The mixed mode uses the same windows, but its last window runs through the tail stages. Windows are processed from the end of the frame towards its start. As a result, the decoded bits always come out from the last information stage down to stage 0.

Top module: `viterbi_traceback`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `cfg_err` and `out_valid` are 0.
- R2: A decision vector written at stage t is used when stage t is traced. From state s at stage t, the emitted bit is s[0], and the next state is {vec_t[s], s[K-2:1]}.
- R3: The decoded bits are emitted in reverse stage order, starting with information stage F-1 and ending with stage 0.
- R4: Mode code 1 (tailed) traces from `start_state` at stage F+K-2. It drops the K-1 bits of the tail stages and emits exactly F bits.
- R5: Mode code 3 (convergent) cuts the frame into windows of R stages, and the highest window is processed first. Every window other than the last starts from state 0 at stage min(hi+C, F)-1, where hi is one past the window's top stage. The bits traced above hi are discarded. The last window starts from `start_state` at stage F-1.
- R6: Mode code 2 (mixed) windows the frame the same way as R5. Its last window starts from `start_state` at stage F+K-2, and the other windows clip their start stage to F+K-2.
- R7: With `msb_first`=0, the n-th emitted bit of a word lands in bit n. With `msb_first`=1, it lands in bit 31-n.
- R8: A frame gives ceil(F/32) words. The unused bits of the final word are zero, and `out_last` is 1 on that word only.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values.
- R10: A start is refused when the mode code is 0, when F is 0, or when the stored stage count exceeds DEPTH. The stored stage count is F+K-1, or F in mode 3. In modes 2 and 3, a start is also refused when R is 0 or when R+C exceeds DEPTH. A refused start sets `cfg_err` on the next edge and produces no output. A later accepted start clears `cfg_err`.
- R11: A start pulse while `busy` is 1 is ignored: the running frame's output is unchanged, and `cfg_err` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one decision vector |
| wr_stage | input | $clog2(DEPTH) | Trellis stage being written |
| wr_vec | input | 2**(K-1) | Decision bit per state |
| start | input | 1 | Launch a traceback |
| mode | input | 2 | 1 tailed, 2 mixed, 3 convergent |
| frame_len | input | LW | Information stages F |
| win_r | input | LW | Decoded stages per window R |
| win_c | input | LW | Convergence stages C |
| start_state | input | K-1 | State holding the final best metric |
| msb_first | input | 1 | Packing order of decoded bits |
| busy | output | 1 | A traceback or its last word is pending |
| cfg_err | output | 1 | Last start was refused |
| out_valid | output | 1 | Word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 32 | Packed decoded bits |
| out_last | output | 1 | Final word of the frame |

## Verification
`cfg_err` changes on the first edge after the start pulse, so the bench reads it at the next falling edge. Words have no fixed latency, because the window seek and the convergence stages depend on R, C and F. The bench therefore decides `out_ready` at each falling edge. It counts a word as delivered only when `out_valid` and its own ready are both high there, because the transfer then happens at the following edge. For stalls, the bench records the held word at a falling edge with ready low and compares it one falling edge later. It checks `busy` and `cfg_err` a few cycles after the last word, when the drain state has had two edges to return to idle.

// File: rtl/vtb_pkg.sv
package vtb_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        MODE_NONE  = 2'd0,
        MODE_TAIL  = 2'd1,
        MODE_MIXED = 2'd2,
        MODE_CONV  = 2'd3
    } tb_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEEK,
        ST_WSTART,
        ST_TRACE,
        ST_DRAIN
    } tb_state_e;

    typedef struct packed {
        logic valid;
        logic value;
        logic final_bit;
    } dec_bit_t;

    function automatic logic [4:0] bit_slot(input logic [4:0] cnt, input logic msb_first);
        return msb_first ? (5'd31 - cnt) : cnt;
    endfunction

endpackage

// File: rtl/vtb_dec_store.sv
module vtb_dec_store #(
    parameter int NS    = 16,
    parameter int DEPTH = 128,
    localparam int SW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_stage,
    input  logic [NS-1:0] wr_vec,
    input  logic [SW-1:0] rd_stage,
    output logic [NS-1:0] rd_vec
);
    logic [NS-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_stage] <= wr_vec;
    end

    assign rd_vec = cells[rd_stage];
endmodule

// File: rtl/vtb_word_pack.sv
module vtb_word_pack
    import vtb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  dec_bit_t    evt,
    input  logic        msb_first,
    output logic        room,
    output logic        idle,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_data,
    output logic        out_last
);
    logic [31:0] acc;
    logic [4:0]  cnt;
    logic [31:0] placed;
    logic [31:0] merged;

    assign placed = 32'(evt.value) << bit_slot(cnt, msb_first);
    assign merged = acc | placed;
    assign room   = !out_valid || out_ready;
    assign idle   = !out_valid && (cnt == 5'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc       <= '0;
            cnt       <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else begin
            if (out_valid && out_ready) out_valid <= 1'b0;
            if (evt.valid) begin
                if (cnt == 5'd31 || evt.final_bit) begin
                    out_data  <= merged;
                    out_last  <= evt.final_bit;
                    out_valid <= 1'b1;
                    acc       <= '0;
                    cnt       <= '0;
                end else begin
                    acc <= merged;
                    cnt <= cnt + 5'd1;
                end
            end
        end
    end

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    assert_push_room_R9: assert property (@(posedge clk) disable iff (rst)
        evt.valid |-> (!out_valid || out_ready));

    assert_final_last_R8: assert property (@(posedge clk) disable iff (rst)
        (evt.valid && evt.final_bit) |=> (out_valid && out_last));
endmodule

// File: rtl/vtb_trace_ctrl.sv
module vtb_trace_ctrl
    import vtb_pkg::*;
#(
    parameter int K     = 5,
    parameter int DEPTH = 128,
    parameter int LW    = 10,
    localparam int SB   = K - 1,
    localparam int NS   = 1 << SB,
    localparam int SW   = $clog2(DEPTH),
    localparam int EW   = LW + 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [1:0]    mode,
    input  logic [LW-1:0] frame_len,
    input  logic [LW-1:0] win_r,
    input  logic [LW-1:0] win_c,
    input  logic [SB-1:0] start_state,
    input  logic          msb_first,
    output logic [SW-1:0] rd_stage,
    input  logic [NS-1:0] rd_vec,
    input  logic          step_ok,
    input  logic          pack_idle,
    output dec_bit_t      evt,
    output logic          order_o,
    output logic          busy,
    output logic          cfg_err
);
    localparam logic [EW-1:0] TAIL = EW'(K - 1);
    localparam logic [EW-1:0] DEP  = EW'(DEPTH);
    localparam logic [EW-1:0] ONE  = EW'(1);

    tb_state_e     st;
    tb_mode_e      c_mode;
    logic [EW-1:0] c_f, c_r, c_c;
    logic [SB-1:0] c_ss;
    logic          c_ord;
    logic [EW-1:0] win_lo, win_hi, cur_stage;
    logic [SB-1:0] cur_state;
    logic          err_q;

    tb_mode_e      in_mode;
    logic [EW-1:0] in_f, in_r, in_c, in_stored;
    logic          in_bad;
    logic [EW-1:0] last_stored, reach, w_hi, conv_top, w_top;
    logic          is_last;
    logic [SB-1:0] pred;
    logic          emit;

    always_comb begin
        in_mode   = tb_mode_e'(mode);
        in_f      = EW'(frame_len);
        in_r      = EW'(win_r);
        in_c      = EW'(win_c);
        in_stored = in_f + ((in_mode == MODE_CONV) ? '0 : TAIL);
        in_bad    = (in_mode == MODE_NONE) || (in_f == '0) || (in_stored > DEP) ||
                    ((in_mode != MODE_TAIL) && ((in_r == '0) || ((in_r + in_c) > DEP)));
    end

    always_comb begin
        last_stored = c_f - ONE + ((c_mode == MODE_CONV) ? '0 : TAIL);
        reach       = win_lo + c_r;
        is_last     = (reach >= c_f);
        w_hi        = is_last ? c_f : reach;
        conv_top    = w_hi + c_c - ONE;
        if (is_last)                    w_top = last_stored;
        else if (conv_top > last_stored) w_top = last_stored;
        else                            w_top = conv_top;
    end

    assign pred     = {rd_vec[cur_state], cur_state[SB-1:1]};
    assign rd_stage = cur_stage[SW-1:0];
    assign emit     = (st == ST_TRACE) && step_ok && (cur_stage < win_hi);

    always_comb begin
        evt.valid     = emit;
        evt.value     = cur_state[0];
        evt.final_bit = (cur_stage == '0);
    end

    assign order_o = c_ord;
    assign busy    = (st != ST_IDLE);
    assign cfg_err = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            err_q     <= 1'b0;
            c_mode    <= MODE_NONE;
            c_f       <= '0;
            c_r       <= '0;
            c_c       <= '0;
            c_ss      <= '0;
            c_ord     <= 1'b0;
            win_lo    <= '0;
            win_hi    <= '0;
            cur_stage <= '0;
            cur_state <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        if (in_bad) begin
                            err_q <= 1'b1;
                        end else begin
                            err_q  <= 1'b0;
                            c_mode <= in_mode;
                            c_f    <= in_f;
                            c_r    <= (in_mode == MODE_TAIL) ? in_f : in_r;
                            c_c    <= in_c;
                            c_ss   <= start_state;
                            c_ord  <= msb_first;
                            win_lo <= '0;
                            st     <= ST_SEEK;
                        end
                    end
                end
                ST_SEEK: begin
                    if (is_last) st <= ST_WSTART;
                    else         win_lo <= reach;
                end
                ST_WSTART: begin
                    win_hi    <= w_hi;
                    cur_stage <= w_top;
                    cur_state <= is_last ? c_ss : '0;
                    st        <= ST_TRACE;
                end
                ST_TRACE: begin
                    if (step_ok) begin
                        cur_state <= pred;
                        if (cur_stage == win_lo) begin
                            if (win_lo == '0) begin
                                st <= ST_DRAIN;
                            end else begin
                                win_lo <= win_lo - c_r;
                                st     <= ST_WSTART;
                            end
                        end else begin
                            cur_stage <= cur_stage - ONE;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (pack_idle) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assert_stage_range_R5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TRACE) |-> ((cur_stage >= win_lo) && (cur_stage <= last_stored)));

    assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE) |=> ($stable(c_mode) && $stable(c_f) && $stable(c_ss)));

    assert_err_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        err_q |-> !emit);
endmodule

// File: rtl/viterbi_traceback.sv
module viterbi_traceback
    import vtb_pkg::*;
#(
    parameter int K     = 5,
    parameter int DEPTH = 128,
    parameter int LW    = 10,
    localparam int SB   = K - 1,
    localparam int NS   = 1 << SB,
    localparam int SW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_stage,
    input  logic [NS-1:0] wr_vec,
    input  logic          start,
    input  logic [1:0]    mode,
    input  logic [LW-1:0] frame_len,
    input  logic [LW-1:0] win_r,
    input  logic [LW-1:0] win_c,
    input  logic [SB-1:0] start_state,
    input  logic          msb_first,
    output logic          busy,
    output logic          cfg_err,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [31:0]   out_data,
    output logic          out_last
);
    logic [SW-1:0] rd_stage;
    logic [NS-1:0] rd_vec;
    logic          room, pk_idle, order_q;
    dec_bit_t      evt;

    vtb_dec_store #(.NS(NS), .DEPTH(DEPTH)) u_store (
        .clk(clk), .wr_en(wr_en), .wr_stage(wr_stage), .wr_vec(wr_vec),
        .rd_stage(rd_stage), .rd_vec(rd_vec)
    );

    vtb_trace_ctrl #(.K(K), .DEPTH(DEPTH), .LW(LW)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .frame_len(frame_len), .win_r(win_r), .win_c(win_c),
        .start_state(start_state), .msb_first(msb_first),
        .rd_stage(rd_stage), .rd_vec(rd_vec), .step_ok(room),
        .pack_idle(pk_idle), .evt(evt), .order_o(order_q),
        .busy(busy), .cfg_err(cfg_err)
    );

    vtb_word_pack u_pack (
        .clk(clk), .rst(rst), .evt(evt), .msb_first(order_q),
        .room(room), .idle(pk_idle), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
    );

    assert_valid_busy_R11: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> busy);
endmodule

// File: tb/test_viterbi_traceback.sv
module test_viterbi_traceback;
    localparam int K = 5, DEPTH = 128, LW = 10;
    localparam int SB = K - 1, NS = 1 << SB, SW = $clog2(DEPTH);

    logic clk = 1'b0, rst = 1'b1;
    logic wr_en = 1'b0;
    logic [SW-1:0] wr_stage = '0;
    logic [NS-1:0] wr_vec = '0;
    logic start = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [LW-1:0] frame_len = '0, win_r = '0, win_c = '0;
    logic [SB-1:0] start_state = '0;
    logic msb_first = 1'b0;
    logic busy, cfg_err, out_valid, out_last;
    logic out_ready = 1'b0;
    logic [31:0] out_data;

    viterbi_traceback #(.K(K), .DEPTH(DEPTH), .LW(LW)) i_viterbi_traceback (.*);

    always #10 clk = ~clk;

    int cyc = 0;
    bit wd_hit = 1'b0;
    int n_chk = 0, n_err = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) wd_hit <= 1'b1;
    end

    logic [NS-1:0] mem_m [DEPTH];
    logic exp_b [DEPTH];
    int nb, nw;
    logic [31:0] exp_w [8];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic load_mem();
        for (int t = 0; t < DEPTH; t++) begin
            wr_en = 1'b1; wr_stage = SW'(t); wr_vec = mem_m[t];
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    task automatic rand_mem();
        for (int t = 0; t < DEPTH; t++) mem_m[t] = NS'($urandom);
    endtask

    // Expected bits from the window rules of R4, R5, R6 and the recursion of R2.
    task automatic model_bits(input int md, input int f, input int r, input int c,
                              input logic [SB-1:0] ss);
        int rr, ls, lo, hi, top;
        logic [SB-1:0] s;
        rr = (md == 1) ? f : r;
        ls = f - 1 + ((md == 3) ? 0 : K - 1);
        lo = ((f - 1) / rr) * rr;
        nb = 0;
        while (lo >= 0) begin
            hi = (lo + rr > f) ? f : lo + rr;
            if (hi == f) top = ls;
            else top = (hi + c - 1 > ls) ? ls : hi + c - 1;
            s = (hi == f) ? ss : '0;
            for (int t = top; t >= lo; t--) begin
                if (t < hi) begin exp_b[nb] = s[0]; nb++; end
                s = {mem_m[t][s], s[SB-1:1]};
            end
            lo -= rr;
        end
    endtask

    // R7 / R8 packing.
    task automatic pack_words(input bit ord);
        nw = (nb + 31) / 32;
        for (int w = 0; w < nw; w++) begin
            exp_w[w] = '0;
            for (int j = 0; j < 32; j++)
                if (32 * w + j < nb) exp_w[w][ord ? 31 - j : j] = exp_b[32 * w + j];
        end
    endtask

    task automatic run(input int md, input int f, input int r, input int c,
                       input logic [SB-1:0] ss, input bit ord, input int rdy_pct,
                       input bit poke, input bit preset, input string req);
        int got, t0;
        bit last_seen, held, hold_l;
        logic [31:0] hold_d;
        if (!preset) model_bits(md, f, r, c, ss);
        pack_words(ord);
        mode = md[1:0]; frame_len = LW'(f); win_r = LW'(r); win_c = LW'(c);
        start_state = ss; msb_first = ord; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got = 0; last_seen = 1'b0; held = 1'b0; hold_l = 1'b0; hold_d = '0; t0 = cyc;
        while (!last_seen && !wd_hit && (cyc - t0 < 20000)) begin
            if (poke && (cyc - t0 == 3)) begin start = 1'b1; mode = 2'd0; end
            else start = 1'b0;
            if (held)
                check(out_valid && out_data == hold_d && out_last == hold_l, "R9",
                      "stalled word changed", out_data, hold_d);
            out_ready = (($urandom % 100) < rdy_pct);
            if (out_valid && out_ready) begin
                if (got < nw) begin
                    check(out_data == exp_w[got], req, "word data (R3/R7)", out_data, exp_w[got]);
                    check(out_last == (got == nw - 1), "R8", "last flag", 32'(out_last),
                          32'(got == nw - 1));
                end
                got++;
                if (out_last) last_seen = 1'b1;
                held = 1'b0;
            end else if (out_valid) begin
                held = 1'b1; hold_d = out_data; hold_l = out_last;
            end else held = 1'b0;
            @(negedge clk);
        end
        start = 1'b0; out_ready = 1'b0;
        check(got == nw, "R8", "word count", 32'(got), 32'(nw));
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R11", "busy after frame", 32'(busy), 32'd0);
        check(cfg_err == 1'b0, poke ? "R11" : "R10", "cfg_err after good frame",
              32'(cfg_err), 32'd0);
    endtask

    task automatic err_case(input int md, input int f, input int r, input int c,
                            input string what);
        bit seen;
        mode = md[1:0]; frame_len = LW'(f); win_r = LW'(r); win_c = LW'(c);
        start = 1'b1; out_ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(cfg_err == 1'b1, "R10", what, 32'(cfg_err), 32'd1);
        seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (out_valid || busy) seen = 1'b1;
            @(negedge clk);
        end
        check(!seen, "R10", {what, " produced activity"}, 32'(seen), 32'd0);
        out_ready = 1'b0;
    endtask

    // Decisions that encode a known input sequence; tail zeros bring state 0 (R2, R3, R4).
    task automatic path_run(input int f, input bit ord, input int rdy);
        logic [SB-1:0] s, ns;
        logic u [DEPTH];
        logic b;
        rand_mem();
        s = '0;
        for (int t = 0; t < f + K - 1; t++) begin
            b = (t < f) ? 1'($urandom) : 1'b0;
            u[t] = b;
            ns = {s[SB-2:0], b};
            mem_m[t][ns] = s[SB-1];
            s = ns;
        end
        load_mem();
        nb = f;
        for (int i = 0; i < f; i++) exp_b[i] = u[f - 1 - i];
        run(1, f, 0, 0, '0, ord, rdy, 1'b0, 1'b1, "R4");
    endtask

    initial begin
        int md, f, r, c;
        repeat (3) @(negedge clk);
        check(!busy && !cfg_err && !out_valid, "R1", "state during reset",
              {29'd0, busy, cfg_err, out_valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !cfg_err && !out_valid, "R1", "state after reset",
              {29'd0, busy, cfg_err, out_valid}, 32'd0);

        path_run(40, 1'b0, 100);
        path_run(77, 1'b1, 50);

        rand_mem(); load_mem();
        run(3, 128, 32, 0, 4'd5, 1'b0, 100, 1'b0, 1'b0, "R5");
        run(3, 64, 16, 112, 4'd9, 1'b1, 60, 1'b0, 1'b0, "R5");
        run(2, 1, 1, 0, 4'd3, 1'b0, 100, 1'b0, 1'b0, "R6");
        run(1, 124, 0, 0, 4'd15, 1'b1, 40, 1'b0, 1'b0, "R4");
        run(2, 100, 30, 98, 4'd7, 1'b0, 70, 1'b0, 1'b0, "R6");

        for (int i = 0; i < 30; i++) begin
            md = 1 + ($urandom % 3);
            f  = (md == 3) ? 1 + ($urandom % DEPTH) : 1 + ($urandom % (DEPTH - K + 1));
            r  = 1 + ($urandom % 64);
            c  = $urandom % 41;
            if (r + c > DEPTH) c = DEPTH - r;
            rand_mem(); load_mem();
            run(md, f, r, c, SB'($urandom), 1'($urandom), (i % 3 == 0) ? 100 : 45,
                1'b0, 1'b0, (md == 1) ? "R4" : (md == 2) ? "R6" : "R5");
        end

        rand_mem(); load_mem();
        run(3, 90, 20, 10, 4'd2, 1'b0, 80, 1'b1, 1'b0, "R11");

        err_case(0, 50, 10, 5, "mode 0 refused");
        err_case(3, 100, 100, 29, "R+C over depth refused");
        err_case(1, 125, 0, 0, "tailed frame over depth refused");
        err_case(2, 40, 0, 4, "zero window refused");
        err_case(3, 0, 8, 8, "empty frame refused");

        run(3, 33, 8, 4, 4'd1, 1'b1, 100, 1'b0, 1'b0, "R10");

        if (wd_hit) check(1'b0, "R1", "watchdog expired", 32'(cyc), 32'd150000);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule